// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-bus command decoder and a non-volatile memory array. A write transaction first loads a start address. The data bytes that follow are then held in a small page latch instead of going straight to the array. The low address bits form an in-page offset that advances after each byte and wraps inside the page. The high bits pick the page and never change during the transaction. If more bytes arrive than the page holds, the later bytes replace the earlier ones.

Only a STOP strobe releases the buffered bytes. On STOP the block raises `busy` and scans the page once in ascending offset order. It issues one memory write strobe for each location that received a byte, and none for the others. It then keeps `busy` high until a fixed number of clock cycles have passed since STOP. A bus START, an abort or a fresh address load before STOP throws the buffer away. While `busy` is high, every input strobe is ignored.

Top module: `page_commit_buf`

## Requirements
- R1: After synchronous reset, `busy` and `mem_we` are 0.
- R2: An address load sets the page (upper ADDR_W-5 bits) and the in-page offset (low 5 bits, PAGE_BYTES=32). Each accepted byte is stored at the current offset, and the offset then advances by one. On commit, the byte is written to address {page, offset}, and the page bits stay the same for every write of one commit.
- R3: The offset wraps from 31 to 0. A byte received at an offset that already holds data replaces it, and only the latest value is committed.
- R4: `mem_we` is never asserted while bytes are being collected, only while `busy` is high.
- R5: A STOP strobe sampled while the buffer holds at least one byte sets `busy` in the next cycle. The write for in-page offset i appears on the outputs i+1 clock edges after the edge that sampled STOP, so the writes come in ascending offset order.
- R6: Only offsets that received a byte since the last address load are written. Other locations of the page get no strobe.
- R7: `busy` stays high for exactly WRITE_CYCLES clock cycles, or PAGE_BYTES+1 cycles if WRITE_CYCLES is smaller.
- R8: A bus START, an abort or an address load sampled before STOP discards all buffered bytes. A later STOP then produces no `busy` and no write.
- R9: While `busy` is high, byte strobes, address loads, START, abort and STOP have no effect. The pointer, the buffer and the busy time are unchanged.
- R10: A STOP with an empty buffer produces no `busy` and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Bus START seen (discards the buffer) |
| addr_load | input | 1 | Load start address strobe |
| addr_in | input | ADDR_W | Start address: page in the upper bits, offset in the low 5 bits |
| byte_stb | input | 1 | Data byte strobe |
| byte_in | input | DATA_W | Data byte |
| bus_stop | input | 1 | Bus STOP strobe (starts the commit) |
| abort_in | input | 1 | Abort strobe (discards the buffer) |
| busy | output | 1 | Write cycle in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The hardest case to reach is the wrap with overwrite. It needs a start offset near the page end and more than 32 bytes before STOP. The bench starts at offset 30 and sends 35 bytes, so it can check offsets that were overwritten and offsets that kept their first value. A second hard case is ignoring input while busy, which is invisible unless later effects are checked. The bench sends strobes during the write cycle and then a byte without a new address load. That byte must land right after the original pointer position, which shows that the ignored strobes left the pointer alone.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SCAN = 2'd1,
    PH_HOLD = 2'd2
  } phase_t;
endpackage

// File: rtl/pcb_page_latch.sv
module pcb_page_latch #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int OFF_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              any_mark
);
  // data store without reset so it maps onto block RAM
  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  mark_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_off] <= wr_data;
    if (rd_en) rd_data <= store[rd_off];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q <= '0;
      rd_hit <= 1'b0;
    end else begin
      if (clr) mark_q <= '0;
      if (wr_en) mark_q[wr_off] <= 1'b1;
      rd_hit <= rd_en & mark_q[rd_off];
    end
  end

  assign any_mark = |mark_q;

  // a discard empties the mask (R8)
  assert_discard_empties_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr_en) |=> !any_mark);
endmodule

// File: rtl/pcb_commit_seq.sv
module pcb_commit_seq
  import pcb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int OFF_W = $clog2(DEPTH),
  parameter int WCYC  = 100,
  parameter int CNT_W = $clog2(WCYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output logic             busy,
  output logic             scan_act,
  output logic [OFF_W-1:0] scan_off,
  output logic             scan_end
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(WCYC - 1);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      busy     <= 1'b0;
      cnt_q    <= '0;
      scan_off <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (go) begin
            ph_q     <= PH_SCAN;
            busy     <= 1'b1;
            cnt_q    <= '0;
            scan_off <= '0;
          end
        end
        PH_SCAN: begin
          cnt_q    <= cnt_q + 1'b1;
          scan_off <= scan_off + 1'b1;
          if (scan_off == LAST_OFF) ph_q <= PH_HOLD;
        end
        PH_HOLD: begin
          if (cnt_q == CNT_END) begin
            busy <= 1'b0;
            ph_q <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign scan_act = (ph_q == PH_SCAN);
  assign scan_end = scan_act && (scan_off == LAST_OFF);

  // the page scan always lies inside the busy window (R5)
  assert_scan_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    scan_act |-> busy);
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              bus_stop,
  input  logic              abort_in,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int PAGE_W   = ADDR_W - OFF_W;
  localparam int BUSY_CYC = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES + 1;

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic              accept, discard, wr_en, go, any_mark;
  logic              scan_act, scan_end;
  logic [OFF_W-1:0]  scan_off;

  assign accept  = !busy;
  assign discard = accept & (bus_start | abort_in | addr_load);
  assign wr_en   = accept & byte_stb;
  assign go      = accept & bus_stop & any_mark;

  // address pointer: page is fixed, offset advances and wraps
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (accept) begin
      if (addr_load) begin
        page_q <= addr_in[ADDR_W-1:OFF_W];
        off_q  <= addr_in[OFF_W-1:0];
      end else if (byte_stb) begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  pcb_page_latch #(
    .DATA_W(DATA_W),
    .DEPTH (PAGE_BYTES),
    .OFF_W (OFF_W)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_off  (off_q),
    .wr_data (byte_in),
    .clr     (discard | scan_end),
    .rd_en   (scan_act),
    .rd_off  (scan_off),
    .rd_data (mem_wdata),
    .rd_hit  (mem_we),
    .any_mark(any_mark)
  );

  pcb_commit_seq #(
    .DEPTH(PAGE_BYTES),
    .OFF_W(OFF_W),
    .WCYC (BUSY_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .busy    (busy),
    .scan_act(scan_act),
    .scan_off(scan_off),
    .scan_end(scan_end)
  );

  // write address registered alongside the latch read
  always_ff @(posedge clk) begin
    if (rst) mem_addr <= '0;
    else     mem_addr <= {page_q, scan_off};
  end

  // ---------------- assertions ----------------
  int unsigned busy_run;
  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_stop));

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == BUSY_CYC));

  assert_pointer_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(off_q) && $stable(page_q)));

  assert_page_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> $stable(mem_addr[ADDR_W-1:OFF_W]));
endmodule

// File: tb/test_page_commit_buf.sv
module test_page_commit_buf;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int PB = 32;
  localparam int W  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_start = 0, addr_load = 0, byte_stb = 0, bus_stop = 0, abort_in = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] byte_in = '0;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #4 clk = ~clk;

  page_commit_buf #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WRITE_CYCLES(W)) i_page_commit_buf (
    .clk(clk), .rst(rst), .bus_start(bus_start), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .bus_stop(bus_stop), .abort_in(abort_in),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  logic [7:0] ram [int];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int due; int addr; int data; } wr_t;
  wr_t wq[$];
  int  edge_n = 0;
  bit  m_busy;
  int  m_cnt, m_page, m_off;
  int  m_buf [PB];
  bit  m_mask [PB];

  function automatic bit m_any();
    for (int i = 0; i < PB; i++) if (m_mask[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    edge_n++;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_page = 0; m_off = 0;
      foreach (m_mask[i]) m_mask[i] = 0;
      wq.delete();
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) m_busy = 0;
    end else begin
      if (bus_start || abort_in || addr_load) foreach (m_mask[i]) m_mask[i] = 0;
      if (addr_load) begin
        m_page = int'(addr_in) / PB;
        m_off  = int'(addr_in) % PB;
      end else if (byte_stb) begin
        m_buf[m_off] = int'(byte_in);
        m_mask[m_off] = 1;
        m_off = (m_off + 1) % PB;
      end
      if (bus_stop && m_any()) begin
        for (int i = 0; i < PB; i++)
          if (m_mask[i]) wq.push_back('{edge_n + 1 + i, m_page * PB + i, m_buf[i]});
        m_busy = 1;
        m_cnt = W;
        foreach (m_mask[i]) m_mask[i] = 0;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit exp_we;
      exp_we = (wq.size() > 0) && (wq[0].due == edge_n);
      chk(busy == m_busy, cur_req, "busy", busy, m_busy);
      chk(mem_we == exp_we, cur_req, "mem_we", mem_we, exp_we);
      if (exp_we) begin
        if (mem_we) begin
          chk(int'(mem_addr) == wq[0].addr, cur_req, "mem_addr", mem_addr, wq[0].addr);
          chk(int'(mem_wdata) == wq[0].data, cur_req, "mem_wdata", mem_wdata, wq[0].data);
        end
        void'(wq.pop_front());
      end
      if (mem_we) ram[int'(mem_addr)] = mem_wdata;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic load(input int a);
    addr_load = 1; addr_in = AW'(a); @(negedge clk); addr_load = 0;
  endtask
  task automatic put(input int d);
    byte_stb = 1; byte_in = DW'(d); @(negedge clk); byte_stb = 0;
  endtask
  task automatic stop_p();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic start_p();
    bus_start = 1; @(negedge clk); bus_start = 0;
  endtask
  task automatic abort_p();
    abort_in = 1; @(negedge clk); abort_in = 0;
  endtask
  task automatic settle();
    repeat (W + 4) @(negedge clk);
  endtask
  task automatic ram_is(input int a, input int d, input string req);
    chk(ram.exists(a), req, "written", a, a);
    if (ram.exists(a)) chk(ram[a] == d, req, "ram data", ram[a], d);
  endtask
  task automatic ram_untouched(input int a, input string req);
    chk(!ram.exists(a), req, "untouched addr", a, a);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(mem_we == 0, "R1", "mem_we after reset", mem_we, 0);

    // R2 / R4 / R5: three bytes from offset 3 of page 9
    cur_req = "R4";
    load('h123); put('hA1); put('hA2); put('hA3);
    repeat (3) @(negedge clk);
    cur_req = "R5";
    stop_p();
    chk(busy == 1, "R5", "busy after STOP", busy, 1);
    repeat (4) @(negedge clk);
    chk(mem_we == 1 && mem_addr == 'h123, "R5", "first write timing", mem_addr, 'h123);
    settle();
    ram_is('h123, 'hA1, "R2"); ram_is('h124, 'hA2, "R2"); ram_is('h125, 'hA3, "R2");
    ram_untouched('h122, "R6"); ram_untouched('h126, "R6");

    // R3: wrap from offset 30 with 35 bytes
    cur_req = "R3";
    load('hA5E);
    for (int i = 0; i < 35; i++) put('h10 + i);
    stop_p();
    settle();
    ram_is('hA5E, 'h30, "R3"); ram_is('hA5F, 'h31, "R3");
    ram_is('hA40, 'h32, "R3"); ram_is('hA41, 'h13, "R3");

    // R6 / R7: single byte, count busy length
    cur_req = "R7";
    load('h7C9); put('h5A);
    stop_p();
    begin
      int n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(n == W, "R7", "busy cycles", n, W);
    end
    repeat (3) @(negedge clk);
    ram_is('h7C9, 'h5A, "R6"); ram_untouched('h7C8, "R6"); ram_untouched('h7CA, "R6");

    // R8: START, abort and reload discard
    cur_req = "R8";
    load('h300); put('h11); put('h22); start_p(); stop_p();
    @(negedge clk);
    chk(busy == 0, "R8", "busy after START discard", busy, 0);
    load('h310); put('h33); abort_p(); stop_p();
    @(negedge clk);
    chk(busy == 0, "R8", "busy after abort discard", busy, 0);
    load('h320); put('h44); load('h330); put('h55); stop_p();
    settle();
    ram_untouched('h300, "R8"); ram_untouched('h301, "R8"); ram_untouched('h310, "R8");
    ram_untouched('h320, "R8"); ram_is('h330, 'h55, "R8");

    // R9: strobes during busy are ignored
    cur_req = "R9";
    load('h400); put('h66); stop_p();
    load('h500); put('h77); put('h88); abort_p(); start_p(); stop_p();
    settle();
    ram_is('h400, 'h66, "R9"); ram_untouched('h500, "R9"); ram_untouched('h401, "R9");
    put('h99); stop_p();
    settle();
    ram_is('h401, 'h99, "R9");

    // R10: STOP with an empty buffer
    cur_req = "R10";
    stop_p();
    chk(busy == 0, "R10", "busy after empty STOP", busy, 0);
    repeat (5) @(negedge clk);
    chk(mem_we == 0, "R10", "no write after empty STOP", mem_we, 0);

    summary();
  end
endmodule